// File: doc/BRIEF.md
# Program Memory Width Bridge

This block lets a 16-bit data path share a 24-bit wide program memory with the instruction fetch path. The memory holds words that may be instructions or data. The fetch port always sees complete 24-bit words. The data port moves 16-bit values. Each stored word splits into a 16-bit upper field and an 8-bit low byte. On data transfers the low byte comes from, or goes to, an 8-bit extension register.

A data write stores the 16-bit value in bits [23:8] of the addressed word, and the current extension register value fills bits [7:0]. A data read returns bits [23:8] on the data read bus and later places bits [7:0] in the extension register. Software can also load the extension register directly and read it at any time. A fetch and a data access can be issued in the same cycle, and both complete. When both ports name the same word, the write lands and the fetch sees the contents from before the write.

Top module: `pm_width_bridge`

## Requirements
- R1: After a synchronous active-high reset, `if_word`, `dp_rdata` and `ext_q` are all zero.
- R2: A data write (`dp_en`=1, `dp_we`=1) stores the 24-bit word {`dp_wdata`, `ext_q`} at `dp_addr`. The data value goes in bits [23:8], and the extension register value present at the request edge goes in bits [7:0].
- R3: A data read (`dp_en`=1, `dp_we`=0) presents bits [23:8] of the addressed word on `dp_rdata` one cycle after the request edge. `dp_rdata` keeps that value until the next data read.
- R4: A data read loads bits [7:0] of the addressed word into `ext_q` at the second clock edge after the request. That is one cycle after `dp_rdata` shows the upper field.
- R5: A fetch (`if_en`=1) presents all 24 bits of the word at `if_addr` on `if_word` one cycle after the request edge. `if_word` holds its value while `if_en` is low.
- R6: Instruction fetches never change `ext_q`.
- R7: `ext_we`=1 loads `ext_wdata` into `ext_q` at the next edge. If a data-read load falls on the same edge, the direct write wins.
- R8: A fetch and a data access to different addresses in the same cycle both complete with their normal latency.
- R9: A fetch and a data write to the same address in the same cycle store the new word. The fetch returns the contents from before the write, and a later fetch returns the new word.
- R10: A data write leaves `dp_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| if_en | input | 1 | Fetch request |
| if_addr | input | ADDR_W | Fetch word address |
| if_word | output | 24 | Fetched 24-bit word |
| dp_en | input | 1 | Data access request |
| dp_we | input | 1 | Data access is a write |
| dp_addr | input | ADDR_W | Data access word address |
| dp_wdata | input | 16 | Data value to store in bits [23:8] |
| dp_rdata | output | 16 | Bits [23:8] of the last word read on the data port |
| ext_we | input | 1 | Direct write of the extension register |
| ext_wdata | input | 8 | Value for the direct write |
| ext_q | output | 8 | Extension register contents |

## Verification
A wrong extension register value does not show up on the data read bus. It shows up in the low byte of the next stored word, which a fetch exposes two cycles after the write request. A stale or misrouted read register shows on `dp_rdata` or `if_word` one cycle after the request. A late or missing low-byte load shows on `ext_q` one cycle after that. Collision order and precedence errors appear in the very fetch or extension value that follows the clashing edge.

// File: rtl/pmwb_pkg.sv
package pmwb_pkg;

    localparam int DATA_W = 16;
    localparam int EXT_W  = 8;
    localparam int WORD_W = DATA_W + EXT_W;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [EXT_W-1:0]  ext_t;
    typedef logic [WORD_W-1:0] word_t;

    // Decoded data-port operation
    typedef struct packed {
        logic rd;
        logic wr;
    } dp_op_t;

    // Source selected for the extension register
    typedef enum logic [1:0] {
        EXT_HOLD   = 2'd0,
        EXT_DIRECT = 2'd1,
        EXT_LOAD   = 2'd2
    } ext_src_e;

    function automatic word_t pack_word(data_t d, ext_t e);
        return {d, e};
    endfunction

    function automatic data_t word_hi(word_t w);
        return w[WORD_W-1:EXT_W];
    endfunction

    function automatic ext_t word_lo(word_t w);
        return w[EXT_W-1:0];
    endfunction

    function automatic dp_op_t decode_dp(logic en, logic we);
        dp_op_t op;
        op.rd = en & ~we;
        op.wr = en & we;
        return op;
    endfunction

endpackage

// File: rtl/pmwb_ram.sv
module pmwb_ram
    import pmwb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  word_t             wr_word,
    input  logic              a_en,
    input  logic [ADDR_W-1:0] a_addr,
    output word_t             a_q,
    input  logic              b_en,
    input  logic [ADDR_W-1:0] b_addr,
    output word_t             b_q
);
    localparam int DEPTH = 1 << ADDR_W;

    word_t mem [DEPTH];

    // Write path: the data port is the only writer
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_word;
        end
    end

    // Read port A: fetch side, sees contents from before a same-edge write
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
        end else if (a_en) begin
            a_q <= mem[a_addr];
        end
    end

    // Read port B: data side
    always_ff @(posedge clk) begin
        if (rst) begin
            b_q <= '0;
        end else if (b_en) begin
            b_q <= mem[b_addr];
        end
    end

endmodule

// File: rtl/pmwb_data_port.sv
module pmwb_data_port
    import pmwb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dp_en,
    input  logic              dp_we,
    input  logic [ADDR_W-1:0] dp_addr,
    input  data_t             dp_wdata,
    input  ext_t              ext_cur,
    input  word_t             rd_word,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output word_t             mem_wr_word,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output data_t             dp_rdata,
    output logic              load_req,
    output ext_t              load_byte
);
    dp_op_t op;
    logic   rd_pend;

    always_comb begin
        op = decode_dp(dp_en, dp_we);
    end

    // Write: 16-bit value high, extension register low
    always_comb begin
        mem_wr_en   = op.wr;
        mem_wr_addr = dp_addr;
        mem_wr_word = pack_word(dp_wdata, ext_cur);
    end

    always_comb begin
        mem_rd_en   = op.rd;
        mem_rd_addr = dp_addr;
    end

    // Marks the cycle in which the read word sits in the port register
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend <= 1'b0;
        end else begin
            rd_pend <= op.rd;
        end
    end

    always_comb begin
        dp_rdata  = word_hi(rd_word);
        load_req  = rd_pend;
        load_byte = word_lo(rd_word);
    end

endmodule

// File: rtl/pmwb_ext_reg.sv
module pmwb_ext_reg
    import pmwb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic direct_we,
    input  ext_t direct_d,
    input  logic load_req,
    input  ext_t load_d,
    output ext_t q
);
    ext_src_e src;

    // Direct write outranks a pending read load
    always_comb begin
        if (direct_we) begin
            src = EXT_DIRECT;
        end else if (load_req) begin
            src = EXT_LOAD;
        end else begin
            src = EXT_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (src)
                EXT_DIRECT: q <= direct_d;
                EXT_LOAD:   q <= load_d;
                default:    q <= q;
            endcase
        end
    end

endmodule

// File: rtl/pm_width_bridge.sv
module pm_width_bridge
    import pmwb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    if_en,
    input  logic [ADDR_W-1:0]       if_addr,
    output logic [WORD_W-1:0]       if_word,
    input  logic                    dp_en,
    input  logic                    dp_we,
    input  logic [ADDR_W-1:0]       dp_addr,
    input  logic [DATA_W-1:0]       dp_wdata,
    output logic [DATA_W-1:0]       dp_rdata,
    input  logic                    ext_we,
    input  logic [EXT_W-1:0]        ext_wdata,
    output logic [EXT_W-1:0]        ext_q
);
    logic              mem_wr_en;
    logic [ADDR_W-1:0] mem_wr_addr;
    word_t             mem_wr_word;
    logic              mem_rd_en;
    logic [ADDR_W-1:0] mem_rd_addr;
    word_t             ram_b_q;
    word_t             ram_a_q;
    logic              load_req;
    ext_t              load_byte;
    ext_t              ext_cur;

    pmwb_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mem_wr_en),
        .wr_addr (mem_wr_addr),
        .wr_word (mem_wr_word),
        .a_en    (if_en),
        .a_addr  (if_addr),
        .a_q     (ram_a_q),
        .b_en    (mem_rd_en),
        .b_addr  (mem_rd_addr),
        .b_q     (ram_b_q)
    );

    pmwb_data_port #(.ADDR_W(ADDR_W)) u_dport (
        .clk         (clk),
        .rst         (rst),
        .dp_en       (dp_en),
        .dp_we       (dp_we),
        .dp_addr     (dp_addr),
        .dp_wdata    (dp_wdata),
        .ext_cur     (ext_cur),
        .rd_word     (ram_b_q),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_word (mem_wr_word),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .dp_rdata    (dp_rdata),
        .load_req    (load_req),
        .load_byte   (load_byte)
    );

    pmwb_ext_reg u_ext (
        .clk       (clk),
        .rst       (rst),
        .direct_we (ext_we),
        .direct_d  (ext_wdata),
        .load_req  (load_req),
        .load_d    (load_byte),
        .q         (ext_cur)
    );

    assign ext_q   = ext_cur;
    assign if_word = ram_a_q;

endmodule

// File: rtl/pmwb_checker.sv
module pmwb_checker
    import pmwb_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  if_en,
    input word_t if_word,
    input logic  dp_en,
    input logic  dp_we,
    input data_t dp_rdata,
    input logic  ext_we,
    input ext_t  ext_wdata,
    input ext_t  ext_q,
    input word_t rd_word
);
    logic rd_d1;
    logic rst_seen = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_d1 <= 1'b0;
        end else begin
            rd_d1 <= dp_en & ~dp_we;
        end
        rst_seen <= rst;
    end

    // R1
    always @(posedge clk) begin
        if (rst_seen && !rst) begin
            reset_zero_chk: assert (if_word == '0 && dp_rdata == '0 && ext_q == '0)
                else $error("outputs not cleared by reset");
        end
    end

    // R7
    ext_direct_chk: assert property (@(posedge clk) disable iff (rst)
        ext_we |=> ext_q == $past(ext_wdata));

    // R4
    ext_load_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_d1 && !ext_we) |=> ext_q == $past(rd_word[EXT_W-1:0]));

    // R6
    ext_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!ext_we && !rd_d1) |=> $stable(ext_q));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(dp_en && !dp_we) |=> $stable(dp_rdata));

    // R5
    fetch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !if_en |=> $stable(if_word));

endmodule

bind pm_width_bridge pmwb_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .if_en     (if_en),
    .if_word   (if_word),
    .dp_en     (dp_en),
    .dp_we     (dp_we),
    .dp_rdata  (dp_rdata),
    .ext_we    (ext_we),
    .ext_wdata (ext_wdata),
    .ext_q     (ext_q),
    .rd_word   (ram_b_q)
);

// File: tb/pm_width_bridge_test.sv
module pm_width_bridge_test;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          if_en;
    logic [AW-1:0] if_addr;
    logic [23:0]   if_word;
    logic          dp_en;
    logic          dp_we;
    logic [AW-1:0] dp_addr;
    logic [15:0]   dp_wdata;
    logic [15:0]   dp_rdata;
    logic          ext_we;
    logic [7:0]    ext_wdata;
    logic [7:0]    ext_q;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pm_width_bridge #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst),
        .if_en(if_en), .if_addr(if_addr), .if_word(if_word),
        .dp_en(dp_en), .dp_we(dp_we), .dp_addr(dp_addr),
        .dp_wdata(dp_wdata), .dp_rdata(dp_rdata),
        .ext_we(ext_we), .ext_wdata(ext_wdata), .ext_q(ext_q)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(string req, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %06h expected %06h", req, act, exp);
        end
    endtask

    task automatic idle();
        if_en = 0; dp_en = 0; dp_we = 0; ext_we = 0;
    endtask

    task automatic set_ext(logic [7:0] v);
        ext_we = 1; ext_wdata = v;
        tick();
        ext_we = 0;
    endtask

    task automatic dwrite(logic [AW-1:0] a, logic [15:0] d);
        dp_en = 1; dp_we = 1; dp_addr = a; dp_wdata = d;
        tick();
        dp_en = 0; dp_we = 0;
    endtask

    task automatic fetch(logic [AW-1:0] a, output logic [23:0] w);
        if_en = 1; if_addr = a;
        tick();
        if_en = 0;
        w = if_word;
    endtask

    task automatic t_reset();
        idle();
        rst = 1;
        repeat (3) tick();
        rst = 0;
        tick();
        check("R1 if_word", if_word, 24'h0);
        check("R1 dp_rdata", {8'h0, dp_rdata}, 24'h0);
        check("R1 ext_q", {16'h0, ext_q}, 24'h0);
    endtask

    task automatic t_write_fetch();
        logic [23:0] w;
        set_ext(8'h5A);
        check("R7 direct ext write", {16'h0, ext_q}, 24'h00005A);
        dwrite(8'd3, 16'h1234);
        fetch(8'd3, w);
        check("R2/R5 packed word", w, 24'h12345A);
        // several patterns and the top address
        for (int i = 0; i < 4; i++) begin
            set_ext(8'(8'h10 * i + 8'h0F));
            dwrite(8'(8'd250 + 8'(i * 2 - 1) + 8'd0) , 16'(16'hA000 + i));
        end
        for (int i = 0; i < 4; i++) begin
            fetch(8'(8'd249 + 8'(i * 2)), w);
            check("R2 pattern", w, {16'(16'hA000 + i), 8'(8'h10 * i + 8'h0F)});
        end
        set_ext(8'hC3);
        dwrite(8'd255, 16'hFFFE);
        fetch(8'd255, w);
        check("R2 top address", w, 24'hFFFEC3);
    endtask

    task automatic t_data_read();
        set_ext(8'h00);
        dp_en = 1; dp_we = 0; dp_addr = 8'd3;
        tick();
        dp_en = 0;
        check("R3 read upper field", {8'h0, dp_rdata}, 24'h001234);
        check("R4 ext not yet loaded", {16'h0, ext_q}, 24'h000000);
        tick();
        check("R4 ext loaded low byte", {16'h0, ext_q}, 24'h00005A);
        tick();
        check("R3 rdata held", {8'h0, dp_rdata}, 24'h001234);
    endtask

    task automatic t_fetch_no_ext();
        logic [23:0] w;
        set_ext(8'h77);
        fetch(8'd3, w);
        fetch(8'd255, w);
        tick();
        check("R6 ext after fetches", {16'h0, ext_q}, 24'h000077);
        tick();
        check("R5 if_word held", if_word, 24'hFFFEC3);
    endtask

    task automatic t_concurrent();
        if_en = 1; if_addr = 8'd3;
        dp_en = 1; dp_we = 1; dp_addr = 8'd10; dp_wdata = 16'hABCD;
        tick();
        idle();
        check("R8 fetch beside write", if_word, 24'h12345A);
        if_en = 1; if_addr = 8'd10;
        dp_en = 1; dp_we = 0; dp_addr = 8'd3;
        tick();
        idle();
        check("R8 fetch new word", if_word, 24'hABCD77);
        check("R8 data read beside fetch", {8'h0, dp_rdata}, 24'h001234);
        tick();
    endtask

    task automatic t_collision();
        logic [23:0] w;
        set_ext(8'h42);
        if_en = 1; if_addr = 8'd3;
        dp_en = 1; dp_we = 1; dp_addr = 8'd3; dp_wdata = 16'hBEEF;
        tick();
        idle();
        check("R9 fetch sees old word", if_word, 24'h12345A);
        check("R10 rdata unchanged by write", {8'h0, dp_rdata}, 24'h001234);
        fetch(8'd3, w);
        check("R9 later fetch sees new word", w, 24'hBEEF42);
    endtask

    task automatic t_precedence();
        set_ext(8'h00);
        dp_en = 1; dp_we = 0; dp_addr = 8'd10;
        tick();
        dp_en = 0;
        ext_we = 1; ext_wdata = 8'h11;
        tick();
        ext_we = 0;
        check("R7 direct beats load", {16'h0, ext_q}, 24'h000011);
        check("R3 rdata of addr 10", {8'h0, dp_rdata}, 24'h00ABCD);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        if_addr = '0; dp_addr = '0; dp_wdata = '0; ext_wdata = '0;
        idle();
        rst = 1;
        t_reset();
        t_write_fetch();
        t_data_read();
        t_fetch_no_ext();
        t_concurrent();
        t_collision();
        t_precedence();
        tick();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule